// File: doc/BRIEF.md
# Loopback Path Steering for a 100 Mb/s PHY

This block sits between the media-independent nibble interface and the line-side symbol path of a 100 Mb/s physical layer. It steers the transmit and receive data streams for normal operation and for three test arrangements. In the first, an external line transceiver loops the line back on itself. In the second, received line data is echoed back to the line. In the third, an internal loopback returns transmit data straight to the receive side. A two-bit mode field picks the arrangement. A separate internal-loopback control bit overrides the field whenever it is set.

Switching into a loopback arrangement takes time to settle in the surrounding analog and clock recovery logic. The block therefore holds both data outputs at their idle codes, and drops a data-valid gate, for a parameterised number of clock cycles after each real change of the effective arrangement into external-transceiver or internal loopback. The default of 13750 cycles equals 550 µs at a 25 MHz nibble clock. Both data outputs are registered, so they follow the inputs with one clock of latency.

Top module: `lb_path_steer`

## Requirements
- R1: With the internal control low and mode field 2'b00, `line_txd_o` equals `mii_txd_i` and `mii_rxd_o` equals `line_rxd_i` as sampled at the previous clock edge, and `data_ok_o` is high.
- R2: Mode 2'b01 (external-transceiver loopback) uses the same routing as R1 once its quiet period has ended.
- R3: Mode 2'b10 (remote echo) drives `line_rxd_i` of the previous edge onto both `line_txd_o` and `mii_rxd_o`. `mii_txd_i` has no effect on either output.
- R4: Mode 2'b11 behaves exactly like 2'b00. Moving between 2'b00 and 2'b11 causes no quiet period.
- R5: While `int_lb_i` is high, the mode field is ignored. `mii_rxd_o` carries `mii_txd_i` of the previous edge and `line_txd_o` stays at `LINE_IDLE`.
- R6: When the effective arrangement changes into external-transceiver or internal loopback at a clock edge, `data_ok_o` is low for exactly `DEAD_CYC` consecutive cycles starting from that edge.
- R7: Whenever `data_ok_o` is low, `line_txd_o` equals `LINE_IDLE` and `mii_rxd_o` equals `MII_IDLE`.
- R8: An input change that leaves the effective arrangement unchanged does not start or restart a quiet period. This covers rewriting the same field value, and changing the field while `int_lb_i` is high.
- R9: A change into normal, reserved or remote-echo operation starts no quiet period. Such a change during a running quiet period ends it at once, so `data_ok_o` is high after that edge.
- R10: During reset both data outputs are at their idle codes and `data_ok_o` is low. The effective arrangement is normal, so a loopback selection already present when reset ends starts a quiet period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Nibble clock |
| rst_n | input | 1 | Active-low reset |
| lb_mode_i | input | 2 | Loopback mode field (00 normal, 01 transceiver loop, 10 remote echo, 11 reserved) |
| int_lb_i | input | 1 | Internal loopback, overrides the mode field |
| mii_txd_i | input | DATA_W | Transmit nibble from the MAC side |
| line_rxd_i | input | DATA_W | Receive data from the line side |
| line_txd_o | output | DATA_W | Transmit data toward the line |
| mii_rxd_o | output | DATA_W | Receive nibble toward the MAC side |
| data_ok_o | output | 1 | Data-valid gate, low during a quiet period |

## Verification
The bench changes the mode field during a running quiet period and while internal loopback is held. A design that restarts its counter on every write would drop the gate for too long there. A design that keys on the raw field instead of the effective arrangement would also drop it too long. The bench toggles between 2'b00 and 2'b11, and enters remote echo from a loopback in mid-quiet. A decoder that treats the reserved code as a loop would show a spurious quiet period, and so would a timer that keeps running after leaving loopback. It counts the exact length of the low window to catch off-by-one counters. It also feeds differing transmit and receive data in every cycle, so a swapped or stale route shows up as a data mismatch.

// File: rtl/lbsel_pkg.sv
package lbsel_pkg;

   // Effective data-path arrangement after the override is applied.
   typedef enum logic [1:0] {
      PATH_NORMAL   = 2'd0,
      PATH_XCVR     = 2'd1,
      PATH_REMOTE   = 2'd2,
      PATH_INTERNAL = 2'd3
   } path_e;

   // Arrangements that need a settling window when entered.
   function automatic logic path_needs_quiet(input path_e p);
      return (p == PATH_XCVR) || (p == PATH_INTERNAL);
   endfunction

endpackage

// File: rtl/lbsel_path_decode.sv
module lbsel_path_decode
   import lbsel_pkg::*;
(
   input  logic [1:0] mode_i,
   input  logic       int_lb_i,
   output path_e      path_o
);

   always_comb begin
      if (int_lb_i) begin
         path_o = PATH_INTERNAL;
      end else begin
         unique case (mode_i)
            2'b01:   path_o = PATH_XCVR;
            2'b10:   path_o = PATH_REMOTE;
            default: path_o = PATH_NORMAL;   // 2'b00 and reserved 2'b11
         endcase
      end
   end

endmodule

// File: rtl/lbsel_quiet_timer.sv
module lbsel_quiet_timer
   import lbsel_pkg::*;
#(
   parameter int unsigned DEAD_CYC = 13750
) (
   input  logic  clk,
   input  logic  rst_n,
   input  path_e path_i,
   output logic  quiet_nxt_o,
   output logic  data_ok_o
);

   localparam int unsigned CNT_W = $clog2(DEAD_CYC + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DEAD_CYC);

   path_e            cur_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;
   logic             changed;

   assign changed = (path_i != cur_q);

   always_comb begin
      if (changed) begin
         cnt_d = path_needs_quiet(path_i) ? CNT_LOAD : '0;
      end else if (cnt_q != '0) begin
         cnt_d = cnt_q - 1'b1;
      end else begin
         cnt_d = '0;
      end
   end

   assign quiet_nxt_o = (cnt_d != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q     <= PATH_NORMAL;
         cnt_q     <= '0;
         data_ok_o <= 1'b0;
      end else begin
         cur_q     <= path_i;
         cnt_q     <= cnt_d;
         data_ok_o <= !quiet_nxt_o;
      end
   end

endmodule

// File: rtl/lbsel_steer_xbar.sv
module lbsel_steer_xbar
   import lbsel_pkg::*;
#(
   parameter int unsigned        DATA_W    = 4,
   parameter logic [DATA_W-1:0]  MII_IDLE  = '0,
   parameter logic [DATA_W-1:0]  LINE_IDLE = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  path_e             path_i,
   input  logic              quiet_i,
   input  logic [DATA_W-1:0] mii_txd_i,
   input  logic [DATA_W-1:0] line_rxd_i,
   output logic [DATA_W-1:0] line_txd_o,
   output logic [DATA_W-1:0] mii_rxd_o
);

   logic [DATA_W-1:0] tx_sel;
   logic [DATA_W-1:0] rx_sel;

   always_comb begin
      unique case (path_i)
         PATH_REMOTE: begin
            tx_sel = line_rxd_i;
            rx_sel = line_rxd_i;
         end
         PATH_INTERNAL: begin
            tx_sel = LINE_IDLE;
            rx_sel = mii_txd_i;
         end
         default: begin
            tx_sel = mii_txd_i;
            rx_sel = line_rxd_i;
         end
      endcase
      if (quiet_i) begin
         tx_sel = LINE_IDLE;
         rx_sel = MII_IDLE;
      end
   end

   // One flop pair per lane, each resetting to its own idle bit.
   for (genvar b = 0; b < DATA_W; b++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            line_txd_o[b] <= LINE_IDLE[b];
            mii_rxd_o[b]  <= MII_IDLE[b];
         end else begin
            line_txd_o[b] <= tx_sel[b];
            mii_rxd_o[b]  <= rx_sel[b];
         end
      end
   end

endmodule

// File: rtl/lb_path_steer.sv
module lb_path_steer
   import lbsel_pkg::*;
#(
   parameter int unsigned       DATA_W    = 4,
   parameter int unsigned       DEAD_CYC  = 13750,
   parameter logic [DATA_W-1:0] MII_IDLE  = '0,
   parameter logic [DATA_W-1:0] LINE_IDLE = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        lb_mode_i,
   input  logic              int_lb_i,
   input  logic [DATA_W-1:0] mii_txd_i,
   input  logic [DATA_W-1:0] line_rxd_i,
   output logic [DATA_W-1:0] line_txd_o,
   output logic [DATA_W-1:0] mii_rxd_o,
   output logic              data_ok_o
);

   if (DATA_W < 1) begin : g_bad_width
      $error("lb_path_steer: DATA_W must be at least 1");
   end
   if (DEAD_CYC < 1) begin : g_bad_dead
      $error("lb_path_steer: DEAD_CYC must be at least 1");
   end

   path_e path_c;
   logic  quiet_nxt;

   lbsel_path_decode u_decode (
      .mode_i   (lb_mode_i),
      .int_lb_i (int_lb_i),
      .path_o   (path_c)
   );

   lbsel_quiet_timer #(
      .DEAD_CYC (DEAD_CYC)
   ) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .path_i      (path_c),
      .quiet_nxt_o (quiet_nxt),
      .data_ok_o   (data_ok_o)
   );

   lbsel_steer_xbar #(
      .DATA_W    (DATA_W),
      .MII_IDLE  (MII_IDLE),
      .LINE_IDLE (LINE_IDLE)
   ) u_xbar (
      .clk        (clk),
      .rst_n      (rst_n),
      .path_i     (path_c),
      .quiet_i    (quiet_nxt),
      .mii_txd_i  (mii_txd_i),
      .line_rxd_i (line_rxd_i),
      .line_txd_o (line_txd_o),
      .mii_rxd_o  (mii_rxd_o)
   );

endmodule

// File: rtl/lbsel_checker.sv
module lbsel_checker #(
   parameter int unsigned       DATA_W    = 4,
   parameter logic [DATA_W-1:0] MII_IDLE  = '0,
   parameter logic [DATA_W-1:0] LINE_IDLE = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        lb_mode_i,
   input logic              int_lb_i,
   input logic [DATA_W-1:0] mii_txd_i,
   input logic [DATA_W-1:0] line_rxd_i,
   input logic [DATA_W-1:0] line_txd_o,
   input logic [DATA_W-1:0] mii_rxd_o,
   input logic              data_ok_o
);

   // R1, R2, R4: forward routing whenever the gate is open
   assert_fwd_paths_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!int_lb_i && lb_mode_i != 2'b10) |=>
         (!data_ok_o || (line_txd_o == $past(mii_txd_i) && mii_rxd_o == $past(line_rxd_i))));

   assert_remote_echo_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!int_lb_i && lb_mode_i == 2'b10) |=>
         (!data_ok_o || (line_txd_o == $past(line_rxd_i) && mii_rxd_o == $past(line_rxd_i))));

   assert_internal_route_R5: assert property (@(posedge clk) disable iff (!rst_n)
      int_lb_i |=> (line_txd_o == LINE_IDLE && (!data_ok_o || mii_rxd_o == $past(mii_txd_i))));

   assert_quiet_on_internal_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(int_lb_i) |=> !data_ok_o);

   assert_idle_when_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !data_ok_o |-> (line_txd_o == LINE_IDLE && mii_rxd_o == MII_IDLE));

   assert_no_quiet_plain_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!int_lb_i && lb_mode_i != 2'b01) |=> data_ok_o);

endmodule

bind lb_path_steer lbsel_checker #(
   .DATA_W    (DATA_W),
   .MII_IDLE  (MII_IDLE),
   .LINE_IDLE (LINE_IDLE)
) u_lbsel_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .lb_mode_i  (lb_mode_i),
   .int_lb_i   (int_lb_i),
   .mii_txd_i  (mii_txd_i),
   .line_rxd_i (line_rxd_i),
   .line_txd_o (line_txd_o),
   .mii_rxd_o  (mii_rxd_o),
   .data_ok_o  (data_ok_o)
);

// File: tb/lb_path_steer_tb_top.sv
module lb_path_steer_tb_top;

   localparam int unsigned DW    = 4;
   localparam int unsigned DEAD  = 20;
   localparam logic [DW-1:0] M_IDLE = 4'h0;
   localparam logic [DW-1:0] L_IDLE = 4'hF;

   // Path codes used by the bench model
   localparam int P_NORM = 0, P_XC = 1, P_REM = 2, P_INT = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    lb_mode = 2'b00;
   logic          int_lb = 1'b0;
   logic [DW-1:0] mii_txd = '0;
   logic [DW-1:0] line_rxd = '0;
   logic [DW-1:0] line_txd;
   logic [DW-1:0] mii_rxd;
   logic          data_ok;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   bit auto_chk = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   lb_path_steer #(
      .DATA_W(DW), .DEAD_CYC(DEAD), .MII_IDLE(M_IDLE), .LINE_IDLE(L_IDLE)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .lb_mode_i(lb_mode), .int_lb_i(int_lb),
      .mii_txd_i(mii_txd), .line_rxd_i(line_rxd),
      .line_txd_o(line_txd), .mii_rxd_o(mii_rxd), .data_ok_o(data_ok)
   );

   // ---------------- reference model, from the requirements ----------------
   int          m_path = P_NORM;
   int          m_left = 0;
   logic [1:0]  m_mode = 2'b00;
   logic        exp_ok = 1'b0;
   logic [DW-1:0] exp_tx = L_IDLE;
   logic [DW-1:0] exp_rx = M_IDLE;

   function automatic int eff_path(input logic [1:0] md, input logic il);
      if (il) return P_INT;
      if (md == 2'b01) return P_XC;
      if (md == 2'b10) return P_REM;
      return P_NORM;
   endfunction

   always @(posedge clk) begin
      int p;
      if (!rst_n) begin
         m_path = P_NORM; m_left = 0; exp_ok = 1'b0;
         exp_tx = L_IDLE; exp_rx = M_IDLE;
      end else begin
         p = eff_path(lb_mode, int_lb);
         m_mode = lb_mode;
         if (p != m_path) begin
            m_left = (p == P_XC || p == P_INT) ? DEAD : 0;
            m_path = p;
         end else if (m_left > 0) begin
            m_left = m_left - 1;
         end
         exp_ok = (m_left == 0);
         if (!exp_ok) begin
            exp_tx = L_IDLE; exp_rx = M_IDLE;
         end else if (p == P_INT) begin
            exp_tx = L_IDLE; exp_rx = mii_txd;
         end else if (p == P_REM) begin
            exp_tx = line_rxd; exp_rx = line_rxd;
         end else begin
            exp_tx = mii_txd; exp_rx = line_rxd;
         end
      end
   end

   function automatic string req_tag();
      if (!exp_ok) return "R6/R7";
      if (m_path == P_INT) return "R5";
      if (m_path == P_REM) return "R3";
      if (m_path == P_XC) return "R2";
      if (m_mode == 2'b11) return "R4";
      return "R1";
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Continuous comparison, sampled away from the active edge
   always @(negedge clk) begin
      if (auto_chk && rst_n) begin
         check({req_tag(), " data_ok"}, 32'(data_ok), 32'(exp_ok));
         check({req_tag(), " line_txd"}, 32'(line_txd), 32'(exp_tx));
         check({req_tag(), " mii_rxd"}, 32'(mii_rxd), 32'(exp_rx));
      end
   end

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   task automatic cyc(input int n);
      repeat (n) begin
         @(negedge clk);
         mii_txd  = DW'($urandom);
         line_rxd = DW'($urandom);
      end
   endtask

   // Watchdog
   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=expired expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      int low_cnt;
      void'($urandom(32'd20240613));

      // R10: reset state
      repeat (3) @(negedge clk);
      check("R10 data_ok in reset", 32'(data_ok), 32'd0);
      check("R10 line_txd in reset", 32'(line_txd), 32'(L_IDLE));
      check("R10 mii_rxd in reset", 32'(mii_rxd), 32'(M_IDLE));
      auto_chk = 1'b1;
      rst_n = 1'b1;
      cyc(5);
      check("R1 gate open after reset", 32'(data_ok), 32'd1);

      // R4: toggling 00 <-> 11 gives no quiet period
      lb_mode = 2'b11; cyc(1);
      check("R4 no quiet on reserved", 32'(data_ok), 32'd1);
      lb_mode = 2'b00; cyc(1);
      check("R4 no quiet back to normal", 32'(data_ok), 32'd1);

      // R6: exact quiet length entering transceiver loopback
      lb_mode = 2'b01;
      low_cnt = 0;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         mii_txd = DW'($urandom); line_rxd = DW'($urandom);
         if (!data_ok) low_cnt++;
         else if (low_cnt > 0) break;
      end
      check("R6 quiet length xcvr", 32'(low_cnt), 32'(DEAD));

      // R8: rewriting the same field does not restart
      lb_mode = 2'b01; cyc(1);
      check("R8 same field rewrite", 32'(data_ok), 32'd1);

      // R9: leaving loopback mid-quiet ends it at once
      lb_mode = 2'b00; cyc(1);
      int_lb = 1'b1; cyc(5);
      check("R6 quiet on internal entry", 32'(data_ok), 32'd0);
      int_lb = 1'b0; lb_mode = 2'b10; cyc(1);
      check("R9 remote entry ends quiet", 32'(data_ok), 32'd1);

      // R8: field changes while internal loopback is held
      int_lb = 1'b1; cyc(DEAD + 2);
      for (int i = 0; i < 4; i++) begin
         lb_mode = 2'(i); cyc(1);
         check("R8 field change under override", 32'(data_ok), 32'd1);
      end

      // R10: loop selection present at reset release starts a quiet period
      int_lb = 1'b0; lb_mode = 2'b01;
      rst_n = 1'b0; cyc(2);
      rst_n = 1'b1; cyc(2);
      check("R10 quiet after reset with loop selected", 32'(data_ok), 32'd0);
      cyc(DEAD + 2);

      // Constrained random phase
      for (int i = 0; i < 4000; i++) begin
         if ($urandom_range(39) == 0) lb_mode = 2'($urandom);
         if ($urandom_range(59) == 0) int_lb = ~int_lb;
         cyc(1);
      end

      done = 1'b1;
      auto_chk = 1'b0;
      summary();
      $finish;
   end

endmodule